// File: doc/BRIEF.md
# Multi-Mode Test Stimulus Generator

This block drives the inputs of an n-bit combinational circuit during off-line self-test. A start pulse begins a run. The run produces a programmed number of patterns, one per enabled clock cycle, and each pattern comes with a valid flag. A done flag rises after the last pattern. A two-bit mode select picks the pattern source for the run:

- **Exhaustive:** a complete shift-register sequence that visits every one of the 2**n input words, including all-zero.
- **Pseudorandom:** a seeded maximal-length shift-register sequence.
- **Weighted:** the same pseudorandom source, but each output group is biased toward more ones or more zeros by combining neighbouring register bits.

One shift register serves all modes. The sequences can be repeated exactly: loading the same seed and starting the same mode gives the same patterns every time. The mode and the per-group weight codes are captured when start is seen, so changing them during a run has no effect until the next start. Dropping enable freezes the run in place: no pattern is lost and none is repeated.

Top module: `tpg_multimode`

## Requirements
- R1: After reset, pattern is all-zero, and valid and done are low.
- R2: In exhaustive mode (mode 00), the first pattern is all-zero, and any 2**n consecutive patterns are all distinct, so every input word appears.
- R3: In exhaustive mode, the word that follows 0...01 is all-zero, and the word that follows all-zero is 10...0. Every other word follows the shift rule of R4.
- R4: In pseudorandom mode (mode 01), the first pattern equals the stored seed. Each later pattern is the previous one shifted right by one bit, with a new top bit equal to the XOR of the register taps (bits 0 and 1 for n = 4). The sequence never reaches all-zero and repeats after 2**n - 1 patterns.
- R5: Two runs in the same mode from the same stored seed give identical pattern sequences.
- R6: A pulse on seed_load stores the seed input, except that an all-zero seed is stored as 0...01.
- R7: In weighted mode (mode 10), output bit i of group g is computed from register bits a = s[i], b = s[(i+1) mod n] and c = s[(i+2) mod n]. The group's weight field weights[2g+1:2g] selects the function: 00 gives a, 01 gives a AND b, 10 gives a OR b, and 11 gives a AND b AND c.
- R8: A run of pat_count patterns (pat_count greater than zero) shows valid high on exactly pat_count enabled cycles. In the cycle after the last valid pattern, done is high and valid is low. Done then stays high until the next start.
- R9: A start with pat_count equal to zero produces no valid pattern, and done is high in the cycle after the start.
- R10: While enable is low, valid is low and pattern keeps its value. When enable returns, the sequence continues with the pattern that would have come next.
- R11: Mode 11 gives the same sequence as mode 01.
- R12: A start during a run abandons that run. Valid is low in the cycle after the start, and the new run begins from the first pattern of its own mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begins a run; captures mode, weights and pat_count |
| enable | input | 1 | Allows one pattern per cycle while high |
| mode | input | 2 | 00 exhaustive, 01 pseudorandom, 10 weighted, 11 pseudorandom |
| seed_load | input | 1 | Stores seed, with all-zero replaced by 0...01 |
| seed | input | WIDTH | Seed value for the shift register |
| weights | input | 2*NGROUPS | Two-bit weight code per output group |
| pat_count | input | CNT_W | Number of patterns in the run |
| pattern | output | WIDTH | Stimulus word |
| valid | output | 1 | Pattern is new this cycle |
| done | output | 1 | Run has ended |

## Verification
The bench uses a 4-bit, two-group configuration.

- **Exhaustive:** a full period plus one wraps back to the first word. This separates a complete sequence from a plain maximal-length one: only the complete sequence shows the all-zero word and the correct neighbours around it.
- **Pseudorandom:** full periods from a normal seed and from a zero seed check the shift rule, the zero-seed substitution and repeatability. Mode 11 is compared against mode 01.
- **Weighted:** every weight code, plus one mixed pair of codes, is checked bit for bit. This tells the AND, OR and three-input AND functions apart, and shows whether groups are mapped to the right bits.
- **Control:** pattern counts of zero, one and many, a pause in enable, and a restart during a run separate off-by-one and hold errors in the run control.

// File: rtl/tpg_pkg.sv
package tpg_pkg;

  typedef enum logic [1:0] {
    MODE_EXH  = 2'b00,
    MODE_PRN  = 2'b01,
    MODE_WGT  = 2'b10,
    MODE_PRN2 = 2'b11
  } tpg_mode_e;

  // Feedback taps for a right-shifting register; bit 0 is always a tap.
  function automatic logic [31:0] tap_mask(input int w);
    case (w)
      2, 3, 4, 6, 7: tap_mask = 32'h0000_0003;
      5:             tap_mask = 32'h0000_0005;
      8:             tap_mask = 32'h0000_001D;
      16:            tap_mask = 32'h0000_100B;
      default:       tap_mask = 32'h0000_0003;
    endcase
  endfunction

  // Biased bit from three register bits under a two-bit weight code.
  function automatic logic weight_bit(input logic [1:0] code,
                                      input logic a, input logic b,
                                      input logic c);
    case (code)
      2'b00:   weight_bit = a;
      2'b01:   weight_bit = a & b;
      2'b10:   weight_bit = a | b;
      default: weight_bit = a & b & c;
    endcase
  endfunction

endpackage

// File: rtl/tpg_lfsr.sv
module tpg_lfsr
  import tpg_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         step,
  input  logic         complete,
  output logic [W-1:0] state_o
);
  localparam logic [31:0]  TAPS32 = tap_mask(W);
  localparam logic [W-1:0] TAPS   = TAPS32[W-1:0];
  localparam logic [W-1:0] ONE    = {{(W-1){1'b0}}, 1'b1};

  logic [W-1:0] state_q;
  logic         zero_slot;   // complete mode: next shift-in bit is inverted
  logic         fb;
  logic [W-1:0] nxt;

  assign zero_slot = complete && (state_q[W-1:1] == '0);
  assign fb        = (^(state_q & TAPS)) ^ zero_slot;
  assign nxt       = {fb, state_q[W-1:1]};
  assign state_o   = state_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     state_q <= ONE;
    else if (load)  state_q <= load_val;
    else if (step)  state_q <= nxt;
  end

  // R3
  zero_insert_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load && complete && state_q == ONE) |=> (state_q == '0));

  // R4
  nonzero_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load && !complete && state_q != '0) |=> (state_q != '0));

endmodule

// File: rtl/tpg_weight.sv
module tpg_weight
  import tpg_pkg::*;
#(
  parameter int W  = 8,
  parameter int NG = 4
) (
  input  logic [W-1:0]    state,
  input  logic [2*NG-1:0] codes,
  output logic [W-1:0]    biased
);
  localparam int GS = W / NG;

  for (genvar g = 0; g < NG; g++) begin : g_grp
    for (genvar i = 0; i < GS; i++) begin : g_bit
      localparam int IDX = g * GS + i;
      assign biased[IDX] = weight_bit(codes[2*g +: 2], state[IDX],
                                      state[(IDX + 1) % W],
                                      state[(IDX + 2) % W]);
    end
  end

endmodule

// File: rtl/tpg_ctrl.sv
module tpg_ctrl #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             enable,
  input  logic [CNT_W-1:0] count,
  output logic             step_o,
  output logic             valid_o,
  output logic             done_o
);
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic             busy_q, last_q, valid_q, done_q;
  logic [CNT_W-1:0] left_q;
  logic             emit;

  assign emit    = busy_q && enable && !start;
  assign step_o  = emit;
  assign valid_o = valid_q;
  assign done_o  = done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      left_q  <= '0;
      last_q  <= 1'b0;
      valid_q <= 1'b0;
      done_q  <= 1'b0;
    end else if (start) begin
      busy_q  <= (count != '0);
      left_q  <= count;
      last_q  <= 1'b0;
      valid_q <= 1'b0;
      done_q  <= (count == '0);
    end else if (emit) begin
      left_q  <= left_q - ONE;
      busy_q  <= (left_q != ONE);
      last_q  <= (left_q == ONE);
      valid_q <= 1'b1;
    end else begin
      valid_q <= 1'b0;
      last_q  <= 1'b0;
      done_q  <= done_q | last_q;
    end
  end

  // R8
  left_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (left_q != '0));

  // R8
  done_valid_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> !valid_q);

  // R9
  empty_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && count == '0) |=> (done_q && !valid_q));

endmodule

// File: rtl/tpg_multimode.sv
module tpg_multimode
  import tpg_pkg::*;
#(
  parameter int WIDTH   = 8,
  parameter int NGROUPS = 4,
  parameter int CNT_W   = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic                 enable,
  input  logic [1:0]           mode,
  input  logic                 seed_load,
  input  logic [WIDTH-1:0]     seed,
  input  logic [2*NGROUPS-1:0] weights,
  input  logic [CNT_W-1:0]     pat_count,
  output logic [WIDTH-1:0]     pattern,
  output logic                 valid,
  output logic                 done
);
  localparam logic [WIDTH-1:0] ONE = {{(WIDTH-1){1'b0}}, 1'b1};

  tpg_mode_e              mode_q;
  logic [2*NGROUPS-1:0]   wts_q;
  logic [WIDTH-1:0]       seed_q;
  logic [WIDTH-1:0]       pat_q;
  logic [WIDTH-1:0]       state;
  logic [WIDTH-1:0]       biased;
  logic [WIDTH-1:0]       init_val;
  logic                   step;
  logic                   complete;

  // Stored seed, never all-zero.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         seed_q <= ONE;
    else if (seed_load) seed_q <= (seed == '0) ? ONE : seed;
  end

  // Run configuration captured at start.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_EXH;
      wts_q  <= '0;
    end else if (start) begin
      mode_q <= tpg_mode_e'(mode);
      wts_q  <= weights;
    end
  end

  assign init_val = (tpg_mode_e'(mode) == MODE_EXH) ? '0 : seed_q;
  assign complete = (mode_q == MODE_EXH);

  tpg_ctrl #(.CNT_W(CNT_W)) i_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .enable  (enable),
    .count   (pat_count),
    .step_o  (step),
    .valid_o (valid),
    .done_o  (done)
  );

  tpg_lfsr #(.W(WIDTH)) i_lfsr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (start),
    .load_val (init_val),
    .step     (step),
    .complete (complete),
    .state_o  (state)
  );

  tpg_weight #(.W(WIDTH), .NG(NGROUPS)) i_weight (
    .state  (state),
    .codes  (wts_q),
    .biased (biased)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    pat_q <= '0;
    else if (step) pat_q <= (mode_q == MODE_WGT) ? biased : state;
  end

  assign pattern = pat_q;

  // R10
  pause_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!valid && $stable(pattern)));

  // R6
  seed_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seed_load |=> (seed_q != '0));

endmodule

// File: tb/test_tpg_multimode.sv
module test_tpg_multimode;
  localparam int W = 4;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0, enable = 1'b0, seed_load = 1'b0;
  logic [1:0]   mode = 2'b00;
  logic [W-1:0] seed = '0;
  logic [3:0]   weights = '0;
  logic [7:0]   pat_count = '0;
  logic [W-1:0] pattern;
  logic         valid, done;

  int n_chk = 0;
  int n_err = 0;
  logic [W-1:0] got [0:39];
  logic [W-1:0] ref_seq [0:39];

  always #2 clk = ~clk;

  tpg_multimode #(.WIDTH(W), .NGROUPS(2), .CNT_W(8)) i_tpg_multimode (
    .clk(clk), .rst_n(rst_n), .start(start), .enable(enable), .mode(mode),
    .seed_load(seed_load), .seed(seed), .weights(weights),
    .pat_count(pat_count), .pattern(pattern), .valid(valid), .done(done)
  );

  task automatic chk(input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Right shift, new top bit = s0 xor s1.
  function automatic logic [3:0] prn_next(input logic [3:0] s);
    return (s >> 1) | (4'((s[0] ^ s[1])) << 3);
  endfunction

  function automatic logic [3:0] exh_next(input logic [3:0] s);
    if (s == 4'd1) return 4'd0;
    if (s == 4'd0) return 4'd8;
    return prn_next(s);
  endfunction

  function automatic logic [3:0] wexp(input logic [3:0] s, input logic [3:0] w);
    logic [3:0] r;
    for (int i = 0; i < 4; i++) begin
      logic a, b, c;
      logic [1:0] code;
      a = s[i]; b = s[(i + 1) % 4]; c = s[(i + 2) % 4];
      code = (i < 2) ? w[1:0] : w[3:2];
      case (code)
        2'b00: r[i] = a;
        2'b01: r[i] = a & b;
        2'b10: r[i] = a | b;
        default: r[i] = a & b & c;
      endcase
    end
    return r;
  endfunction

  task automatic load_seed(input logic [3:0] s);
    @(negedge clk); seed = s; seed_load = 1'b1;
    @(negedge clk); seed_load = 1'b0;
  endtask

  task automatic run(input logic [1:0] m, input int cnt, input logic [3:0] w);
    @(negedge clk);
    mode = m; pat_count = 8'(cnt); weights = w; enable = 1'b1; start = 1'b1;
    @(negedge clk); start = 1'b0;
    for (int k = 0; k < cnt; k++) begin
      @(negedge clk);
      got[k] = pattern;
      chk("R8 valid during run", 32'(valid), 32'd1);
    end
    @(negedge clk);
    chk("R8 done after last, valid low", {valid, done}, 32'b01);
  endtask

  initial begin
    #(4 * 150000);
    n_err++;
    $display("FAIL R8 watchdog: actual hung expected finished");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    logic [3:0] s;
    logic [15:0] seen;
    int ones;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 reset outputs", {pattern, valid, done}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after release", {pattern, valid, done}, 32'h0);

    // R2 / R3 exhaustive, one period plus one
    run(2'b00, 17, 4'h0);
    seen = '0;
    for (int k = 0; k < 16; k++) seen[got[k]] = 1'b1;
    ones = $countones(seen);
    chk("R2 all words seen", 32'(ones), 32'd16);
    chk("R2 first word zero", 32'(got[0]), 32'h0);
    chk("R2 wraps after 2**n", 32'(got[16]), 32'(got[0]));
    for (int k = 0; k < 16; k++)
      chk("R3 exhaustive order", 32'(got[k+1]), 32'(exh_next(got[k])));

    // R4 / R6 pseudorandom from seed
    load_seed(4'b1011);
    run(2'b01, 16, 4'h0);
    chk("R4 first equals seed", 32'(got[0]), 32'hB);
    for (int k = 0; k < 15; k++) begin
      chk("R4 shift rule", 32'(got[k+1]), 32'(prn_next(got[k])));
      chk("R4 never zero", 32'(got[k] != 0), 32'd1);
    end
    chk("R4 period 2**n-1", 32'(got[15]), 32'(got[0]));
    for (int k = 0; k < 16; k++) ref_seq[k] = got[k];

    // R5 repeatability
    run(2'b01, 16, 4'h0);
    for (int k = 0; k < 16; k++)
      chk("R5 same seed same sequence", 32'(got[k]), 32'(ref_seq[k]));

    // R11 mode 11 equals mode 01
    run(2'b11, 16, 4'h0);
    for (int k = 0; k < 16; k++)
      chk("R11 mode 11 sequence", 32'(got[k]), 32'(ref_seq[k]));

    // R7 weighted, every code and a mixed pair
    for (int wc = 0; wc < 5; wc++) begin
      logic [3:0] w;
      w = (wc < 4) ? {2'(wc), 2'(wc)} : 4'b1101;
      run(2'b10, 15, w);
      s = 4'b1011;
      for (int k = 0; k < 15; k++) begin
        chk("R7 weighted bits", 32'(got[k]), 32'(wexp(s, w)));
        s = prn_next(s);
      end
    end

    // R6 zero seed replaced by 0...01
    load_seed(4'b0000);
    run(2'b01, 2, 4'h0);
    chk("R6 zero seed start", 32'(got[0]), 32'h1);
    chk("R6 zero seed next", 32'(got[1]), 32'h8);

    // R9 empty run
    @(negedge clk);
    mode = 2'b01; pat_count = 8'd0; start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk("R9 done next cycle, no valid", {valid, done}, 32'b01);
    repeat (2) @(negedge clk);
    chk("R9 still no valid", {valid, done}, 32'b01);

    // R8 single pattern, done held
    load_seed(4'b0110);
    run(2'b01, 1, 4'h0);
    chk("R8 single pattern", 32'(got[0]), 32'h6);
    repeat (3) @(negedge clk);
    chk("R8 done held", {valid, done}, 32'b01);

    // R10 pause mid-run
    load_seed(4'b1011);
    @(negedge clk);
    mode = 2'b01; pat_count = 8'd8; enable = 1'b1; start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk("R8 done cleared by start", 32'(done), 32'd0);
    s = 4'b1011;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R10 before pause", {valid, pattern}, {1'b1, s});
      if (k < 2) s = prn_next(s);
    end
    enable = 1'b0;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R10 paused hold", {valid, pattern}, {1'b0, s});
    end
    enable = 1'b1;
    for (int k = 3; k < 8; k++) begin
      s = prn_next(s);
      @(negedge clk);
      chk("R10 resume sequence", {valid, pattern}, {1'b1, s});
    end
    @(negedge clk);
    chk("R10 done after paused run", {valid, done}, 32'b01);

    // R12 restart during a run
    @(negedge clk);
    mode = 2'b01; pat_count = 8'd10; start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (2) @(negedge clk);
    mode = 2'b00; pat_count = 8'd3; start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk("R12 valid low after restart", {valid, done}, 32'b00);
    s = 4'h0;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R12 new run sequence", {valid, pattern}, {1'b1, s});
      s = exh_next(s);
    end
    @(negedge clk);
    chk("R12 done after new run", {valid, done}, 32'b01);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule